// File: doc/BRIEF.md
# Addend-Compensated PTP Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day count for IEEE 1588 timestamping. It runs on a reference clock that is faster than the nominal tick rate. On every reference cycle a 32-bit frequency-compensation addend is summed into a 32-bit phase accumulator. Each carry out of that sum makes one nominal tick, and each tick moves the time forward by a programmed period in nanoseconds. Software trims the clock rate in parts per billion by changing the addend.

For a rate ratio R, meaning the reference frequency divided by the nominal tick frequency, with R strictly above 1, the nominal addend is ceil(2^32 / R). The highest adjustment software may apply is 1e9*(R-1)-1 ppb. As an example, a 250 MHz reference with a 10 ns period gives R = 2.5 and an addend of 0x66666667.

Software uses one plain write port to load the addend, the period, the time and a stored 2-bit clock-source field. The time and that field are always visible on the outputs. The tick strobe goes to downstream prescaler and pulse-generator logic. Clock multiplexing is done outside the block; the source field is only stored.

Top module: `ptp_time_counter`

## Requirements
- R1: While rst_n is low and after it is released, time_ns is 0, tick_en is 0 and clk_src is 1. The addend starts at ceil(2^32*NOM_KHZ/REF_KHZ) (0x66666667 by default) and the period starts at PERIOD_RST (10 ns by default).
- R2: On every clk_ref edge the accumulator becomes (accumulator + addend) mod 2^32. tick_en is high for the one cycle after an edge whose sum carried out of bit 31, and is low otherwise.
- R3: At an edge where tick_en is high, time_ns increases by the period. With no tick and no load, time_ns holds.
- R4: Writing the addend (wr_sel 0, wr_data[31:0]) changes the addend used from the next edge on. The accumulator and the time are not cleared.
- R5: Writing the period (wr_sel 1, wr_data[PER_W-1:0]) sets the step used by every later tick.
- R6: Writing wr_sel 2 stages the low 32 time bits and leaves time_ns unchanged. Writing wr_sel 3 loads time_ns with {wr_data, staged low} in a single step at that edge. This load takes priority over a tick at the same edge.
- R7: Writing wr_sel 4 stores wr_data[1:0] as clk_src (0 external precision clock, 1 system clock, 2 transmit clock, 3 RTC input). The field has no effect on counting.
- R8: time_ns wraps modulo 2^64.
- R9: With an addend of 0, tick_en stays low and time_ns does not move.
- R10: A write with wr_sel 5, 6 or 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| time_ns | output | 64 | Current time of day in nanoseconds |
| tick_en | output | 1 | One-cycle nominal tick strobe |
| clk_src | output | 2 | Stored clock-source select field |

## Verification
The assertions assume that rst_n is asynchronous and that every input is stable around the rising clk_ref edge. They also assume that a time load and a tick at the same edge resolve in favour of the load, so the advance check is gated off during loads. The stimulus changes inputs only at falling edges and holds each write for a single cycle. It walks addends from 0 up to all ones, so that both long gaps between ticks and ticks on back-to-back cycles appear in the run.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [2:0] {
    SEL_ADDEND  = 3'd0,
    SEL_PERIOD  = 3'd1,
    SEL_TIME_LO = 3'd2,
    SEL_TIME_HI = 3'd3,
    SEL_SRC     = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_SYS = 2'd1,
    SRC_TX  = 2'd2,
    SRC_RTC = 2'd3
  } clk_src_e;

  // ceil(2^32 * nominal / reference), both rates in kHz
  function automatic logic [31:0] nominal_addend(input longint unsigned ref_khz,
                                                 input longint unsigned nom_khz);
    longint unsigned num;
    num = (64'd1 << 32) * nom_khz;
    return 32'((num + ref_khz - 1) / ref_khz);
  endfunction
endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
  import ptp_tc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADD_W      = 32,
  parameter int PER_W      = 16,
  parameter int TIME_W     = 64,
  parameter logic [ADD_W-1:0] ADD_RST = '0,
  parameter logic [PER_W-1:0] PER_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADD_W-1:0]  addend_o,
  output logic [PER_W-1:0]  period_o,
  output logic [1:0]        src_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [DATA_W-1:0] lo_stage_q;
  clk_src_e          src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_o   <= ADD_RST;
      period_o   <= PER_RST;
      lo_stage_q <= '0;
      src_q      <= SRC_SYS;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_ADDEND:  addend_o   <= wr_data[ADD_W-1:0];
        SEL_PERIOD:  period_o   <= wr_data[PER_W-1:0];
        SEL_TIME_LO: lo_stage_q <= wr_data;
        SEL_SRC:     src_q      <= clk_src_e'(wr_data[1:0]);
        default: ;
      endcase
    end
  end

  assign src_o      = src_q;
  assign load_o     = wr_en && (reg_sel_e'(wr_sel) == SEL_TIME_HI);
  assign load_val_o = {wr_data[HI_W-1:0], lo_stage_q};

  assert_src_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4) |=> src_o == $past(wr_data[1:0]));

  assert_bad_sel_keeps_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > 3'd4) |=> ($stable(addend_o) && $stable(period_o) && $stable(src_o)));
endmodule

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int ADD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ADD_W-1:0] acc_q;
  logic [ADD_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, addend_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= sum[ADD_W-1:0];
      tick_o <= sum[ADD_W];
    end
  end

  // a carry is exactly a decrease of the accumulator value
  assert_tick_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tick_o == (acc_q < $past(acc_q)));

  assert_zero_addend_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addend_i == '0) |=> !tick_o);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int TIME_W = 64,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      time_o <= '0;
    else if (load_i) time_o <= load_val_i;
    else if (tick_i) time_o <= time_o + TIME_W'(period_i);
  end

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(time_o));

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (time_o - $past(time_o)) == TIME_W'($past(period_i)));

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> time_o == $past(load_val_i));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADD_W      = 32,
  parameter int PER_W      = 16,
  parameter int TIME_W     = 64,
  parameter longint unsigned REF_KHZ = 250000,
  parameter int PERIOD_RST = 10
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              tick_en,
  output logic [1:0]        clk_src
);
  localparam longint unsigned NOM_KHZ = 64'd1000000 / 64'(PERIOD_RST);
  localparam logic [ADD_W-1:0] ADD_RST = ADD_W'(nominal_addend(REF_KHZ, NOM_KHZ));
  localparam logic [PER_W-1:0] PER_RST = PER_W'(PERIOD_RST);

  logic [ADD_W-1:0]  addend;
  logic [PER_W-1:0]  period;
  logic              load;
  logic [TIME_W-1:0] load_val;

  ptp_cfg_regs #(
    .DATA_W(DATA_W), .ADD_W(ADD_W), .PER_W(PER_W), .TIME_W(TIME_W),
    .ADD_RST(ADD_RST), .PER_RST(PER_RST)
  ) u_cfg (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .addend_o(addend), .period_o(period),
    .src_o(clk_src), .load_o(load), .load_val_o(load_val)
  );

  ptp_phase_acc #(.ADD_W(ADD_W)) u_acc (
    .clk(clk_ref), .rst_n(rst_n), .addend_i(addend), .tick_o(tick_en)
  );

  ptp_tod_counter #(.TIME_W(TIME_W), .PER_W(PER_W)) u_tod (
    .clk(clk_ref), .rst_n(rst_n), .tick_i(tick_en), .period_i(period),
    .load_i(load), .load_val_i(load_val), .time_o(time_ns)
  );

  initial begin
    assert_params_R1: assert (TIME_W == 2 * DATA_W && ADD_W <= DATA_W && PER_W <= DATA_W);
  end

  assert_lo_write_keeps_time_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2 && !tick_en) |=> $stable(time_ns));
endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_ns;
  logic        tick_en;
  logic [1:0]  clk_src;

  always #5 clk = ~clk;

  ptp_time_counter dut (
    .clk_ref(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .time_ns(time_ns), .tick_en(tick_en), .clk_src(clk_src)
  );

  // bench model state, derived from the requirements
  logic [31:0] acc_m, add_m, lo_m;
  logic [15:0] per_m;
  logic [63:0] time_m;
  logic        tick_m;
  logic [1:0]  src_m;
  int errors = 0, checks = 0, mism = 0, ticks_seen = 0;
  bit done = 0;

  // {addend, period, cycles}
  localparam logic [95:0] VEC [6] = '{
    {32'h8000_0000, 32'd10, 32'd40},
    {32'hFFFF_FFFF, 32'd8,  32'd40},
    {32'h0000_0001, 32'd5,  32'd20},
    {32'h6666_6667, 32'd10, 32'd60},
    {32'h4000_0000, 32'd3,  32'd50},
    {32'h9999_99A4, 32'd10, 32'd50}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [32:0] s;
    @(posedge clk);
    s = {1'b0, acc_m} + {1'b0, add_m};
    if (wr_en && wr_sel == 3'd3) time_m = {wr_data, lo_m};
    else if (tick_m) time_m = time_m + 64'(per_m);
    tick_m = s[32];
    acc_m  = s[31:0];
    if (wr_en) begin
      case (wr_sel)
        3'd0: add_m = wr_data;
        3'd1: per_m = wr_data[15:0];
        3'd2: lo_m  = wr_data;
        3'd4: src_m = wr_data[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (time_ns !== time_m || tick_en !== tick_m || clk_src !== src_m) mism++;
    if (tick_en) ticks_seen++;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic lockstep(input string req);
    check(mism == 0, req, 64'(mism), 64'd0);
    mism = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] t0;
    acc_m = '0; lo_m = '0; time_m = '0; tick_m = 1'b0; src_m = 2'd1; per_m = 16'd10;
    add_m = 32'((((64'd1 << 32) * 64'd100000) + 64'd250000 - 1) / 64'd250000);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(time_ns == 64'd0, "R1 time", time_ns, 0);
    check(tick_en == 1'b0, "R1 tick", 64'(tick_en), 0);
    check(clk_src == 2'd1, "R1 src", 64'(clk_src), 1);
    check(add_m == 32'h6666_6667, "R1 addend formula", 64'(add_m), 64'h6666_6667);
    rst_n = 1'b1;
    mism = 0;
    run(30);
    lockstep("R1 default rate");

    // R2 R3 R4 R5: table of addend/period patterns
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, VEC[i][95:64]);
      wr(3'd1, VEC[i][63:32]);
      run(int'(VEC[i][31:0]));
      lockstep($sformatf("R2 R3 vector %0d", i));
    end

    // R2: all-ones addend gives ticks on nearly every cycle
    wr(3'd0, 32'hFFFF_FFFF);
    ticks_seen = 0;
    run(20);
    check(ticks_seen >= 19, "R2 dense ticks", 64'(ticks_seen), 19);
    lockstep("R2 dense lockstep");

    // R4: addend change mid-run keeps time and phase
    wr(3'd0, 32'h8000_0000);
    run(3);
    t0 = time_ns;
    wr(3'd0, 32'hC000_0000);
    check(time_ns >= t0, "R4 time not cleared", time_ns, t0);
    run(10);
    lockstep("R4 addend change");

    // R5: period change
    wr(3'd1, 32'd7);
    run(12);
    lockstep("R5 period change");

    // R6: staged low then atomic load, overriding a tick
    wr(3'd0, 32'hFFFF_FFFF);
    run(2);
    t0 = time_ns;
    wr(3'd2, 32'hDEAD_BEEF);
    check(time_ns == t0 + 64'(per_m) || time_ns == t0, "R6 low staging", time_ns, t0);
    wr(3'd3, 32'h0000_1234);
    check(time_ns == 64'h0000_1234_DEAD_BEEF, "R6 atomic load", time_ns,
          64'h0000_1234_DEAD_BEEF);
    run(5);
    lockstep("R6 lockstep");

    // R7: clock source field
    wr(3'd4, 32'hFFFF_FFF2);
    check(clk_src == 2'd2, "R7 src write", 64'(clk_src), 2);
    run(6);
    lockstep("R7 counting unaffected");

    // R8: wrap at 2^64
    wr(3'd1, 32'd10);
    wr(3'd2, 32'hFFFF_FFF8);
    wr(3'd3, 32'hFFFF_FFFF);
    run(3);
    check(time_ns < 64'd100, "R8 wrap", time_ns, time_m);
    lockstep("R8 lockstep");

    // R9: zero addend freezes ticks and time
    wr(3'd0, 32'd0);
    run(2);
    t0 = time_ns;
    ticks_seen = 0;
    run(25);
    check(ticks_seen == 0, "R9 no ticks", 64'(ticks_seen), 0);
    check(time_ns == t0, "R9 time frozen", time_ns, t0);

    // R10: unused selects change nothing
    wr(3'd5, 32'h1234_5678);
    wr(3'd6, 32'h0000_0000);
    wr(3'd7, 32'hFFFF_FFFF);
    run(4);
    check(time_ns == t0 && clk_src == 2'd2, "R10 ignored selects", time_ns, t0);
    wr(3'd0, 32'h8000_0000);
    run(8);
    lockstep("R10 state intact");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule